// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of a memory operand into the addresses that a processor drives onto its bus. It takes the contents of the four pointer registers (two base registers, called BX and BP here, and two index registers, SI and DI), a displacement word and a set of mode selects. From these it adds up a 16-bit effective address. It then chooses one of four segment registers and forms a 20-bit physical address. The segment value is shifted left by four bit positions and the offset is added to it.

A request can instead ask for an instruction-fetch address. In that case the code segment and the instruction pointer are used, and the operand fields are ignored. Register combinations that cannot be encoded, and an unused displacement code, raise an illegal flag. All results come out of one register stage and are qualified by a valid strobe one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (selected segment value × 16) + effective address, taken modulo 2^20.
- R2: The effective address is the sum, modulo 2^16, of every register whose bit is set in `use_mask` (bit 0 BX, bit 1 BP, bit 2 SI, bit 3 DI) plus the displacement term.
- R3: `disp_mode` selects the displacement term: 0 gives no displacement, 1 gives `disp[7:0]` sign-extended to 16 bits with `disp[15:8]` ignored, and 2 gives the full 16-bit `disp`.
- R4: For an operand request without the string flag, `seg_code` is SS (2) when BP is selected and DS (3) otherwise. This includes a request with no registers, which is a direct address.
- R5: For an operand request with `str_dst` set, `seg_code` is ES (0), and this takes priority over the BP rule.
- R6: With `req_fetch` set, `seg_code` is CS (1), the effective address is `ip`, and `illegal` is 0, whatever `use_mask`, `disp_mode` and `str_dst` hold.
- R7: For an operand request, selecting BX together with BP, or SI together with DI, sets `illegal`. Whenever `illegal` is set, `ea` and `pa` are zero.
- R8: A register-indirect operand (no displacement) whose only pointer is BP is illegal.
- R9: An operand request with `disp_mode` = 3 is illegal.
- R10: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. When `req_valid` is low, the result outputs keep their values.
- R11: After reset, `out_valid`, `illegal`, `seg_code`, `ea` and `pa` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_fetch | input | 1 | Request is an instruction-fetch address |
| str_dst | input | 1 | Operand is a string destination |
| use_mask | input | 4 | Register select: bit0 BX, bit1 BP, bit2 SI, bit3 DI |
| disp_mode | input | 2 | 0 none, 1 short, 2 long, 3 reserved |
| disp | input | 16 | Displacement word |
| ip | input | 16 | Instruction pointer |
| reg_bx | input | 16 | BX base register value |
| reg_bp | input | 16 | BP base register value |
| reg_si | input | 16 | SI index register value |
| reg_di | input | 16 | DI index register value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| out_valid | output | 1 | Result valid |
| ea | output | 16 | Effective address |
| pa | output | 20 | Physical address |
| seg_code | output | 2 | Chosen segment: 0 ES, 1 CS, 2 SS, 3 DS |
| illegal | output | 1 | Illegal combination flag |

## Verification
The hardest cases to reach are the wrap-around edges. An effective-address sum must carry past bit 15, and a segment base near the top of the 20-bit space must overflow when the offset is added. Uniform random register values reach these edges only rarely. Directed requests therefore put all-ones registers and segments against small offsets, and they pair a negative short displacement with its upper `disp` byte filled with noise. Random requests, with fetch and string flags set at a low rate, cover the priority between the fetch, string and BP rules.

// File: rtl/sag_pkg.sv
package sag_pkg;
   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_code_e;

   typedef enum logic [1:0] {
      DISP_NONE  = 2'd0,
      DISP_SHORT = 2'd1,
      DISP_LONG  = 2'd2,
      DISP_RSVD  = 2'd3
   } disp_mode_e;

   localparam int USE_BX = 0;
   localparam int USE_BP = 1;
   localparam int USE_SI = 2;
   localparam int USE_DI = 3;
   localparam int USE_W  = 4;
endpackage

// File: rtl/sag_ea_sum.sv
module sag_ea_sum #(
   parameter int OFS_W    = 16,
   parameter int SHORT_W  = 8,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [sag_pkg::USE_W-1:0] use_mask,
   input  logic [1:0]                disp_mode,
   input  logic [OFS_W-1:0]          disp,
   input  logic [OFS_W-1:0]          reg_bx,
   input  logic [OFS_W-1:0]          reg_bp,
   input  logic [OFS_W-1:0]          reg_si,
   input  logic [OFS_W-1:0]          reg_di,
   output logic [OFS_W-1:0]          ea_raw
);
   import sag_pkg::*;

   localparam int PAD_W = OFS_W - SHORT_W;

   logic [OFS_W-1:0] short_ext;
   logic [OFS_W-1:0] disp_term;
   logic [OFS_W-1:0] base_term;
   logic [OFS_W-1:0] index_term;

   if (SHORT_W < 1 || SHORT_W >= OFS_W) begin : g_bad_short
      $error("sag_ea_sum: SHORT_W must lie between 1 and OFS_W-1");
   end

   if (SIGN_EXT) begin : g_sext
      assign short_ext = {{PAD_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
   end else begin : g_zext
      assign short_ext = {{PAD_W{1'b0}}, disp[SHORT_W-1:0]};
   end

   always_comb begin
      unique case (disp_mode_e'(disp_mode))
         DISP_SHORT: disp_term = short_ext;
         DISP_LONG:  disp_term = disp;
         default:    disp_term = '0;
      endcase
   end

   always_comb begin
      base_term  = (use_mask[USE_BX] ? reg_bx : '0) + (use_mask[USE_BP] ? reg_bp : '0);
      index_term = (use_mask[USE_SI] ? reg_si : '0) + (use_mask[USE_DI] ? reg_di : '0);
      ea_raw     = base_term + index_term + disp_term;
   end
endmodule

// File: rtl/sag_legal_chk.sv
module sag_legal_chk (
   input  logic                      req_fetch,
   input  logic [sag_pkg::USE_W-1:0] use_mask,
   input  logic [1:0]                disp_mode,
   output logic                      illegal
);
   import sag_pkg::*;

   logic two_bases;
   logic two_indexes;
   logic bp_indirect;
   logic rsvd_disp;

   always_comb begin
      two_bases   = use_mask[USE_BX] & use_mask[USE_BP];
      two_indexes = use_mask[USE_SI] & use_mask[USE_DI];
      bp_indirect = (use_mask == (USE_W'(1) << USE_BP)) &&
                    (disp_mode_e'(disp_mode) == DISP_NONE);
      rsvd_disp   = (disp_mode_e'(disp_mode) == DISP_RSVD);
      illegal     = !req_fetch & (two_bases | two_indexes | bp_indirect | rsvd_disp);
   end
endmodule

// File: rtl/sag_seg_pick.sv
module sag_seg_pick #(
   parameter int SEG_W = 16
) (
   input  logic             req_fetch,
   input  logic             str_dst,
   input  logic             uses_bp,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   output logic [1:0]       seg_code,
   output logic [SEG_W-1:0] seg_val
);
   import sag_pkg::*;

   seg_code_e pick;

   always_comb begin
      if (req_fetch)    pick = SEG_CS;
      else if (str_dst) pick = SEG_ES;
      else if (uses_bp) pick = SEG_SS;
      else              pick = SEG_DS;
   end

   always_comb begin
      unique case (pick)
         SEG_ES:  seg_val = seg_es;
         SEG_CS:  seg_val = seg_cs;
         SEG_SS:  seg_val = seg_ss;
         default: seg_val = seg_ds;
      endcase
   end

   assign seg_code = pick;
endmodule

// File: rtl/sag_pa_sum.sv
module sag_pa_sum #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4
) (
   input  logic [OFS_W-1:0]           seg_val,
   input  logic [OFS_W-1:0]           offset,
   output logic [OFS_W+SEG_SHIFT-1:0] pa_raw
);
   localparam int PA_W = OFS_W + SEG_SHIFT;

   if (SEG_SHIFT < 0 || SEG_SHIFT > OFS_W) begin : g_bad_shift
      $error("sag_pa_sum: SEG_SHIFT out of range");
   end

   if (SEG_SHIFT == 0) begin : g_flat
      assign pa_raw = seg_val + offset;
   end else begin : g_shifted
      logic [PA_W-1:0] base_w;
      logic [PA_W-1:0] ofs_w;
      assign base_w = {seg_val, {SEG_SHIFT{1'b0}}};
      assign ofs_w  = {{SEG_SHIFT{1'b0}}, offset};
      assign pa_raw = base_w + ofs_w;
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int SHORT_W   = 8,
   parameter bit SIGN_EXT  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_fetch,
   input  logic                     str_dst,
   input  logic [3:0]               use_mask,
   input  logic [1:0]               disp_mode,
   input  logic [OFS_W-1:0]         disp,
   input  logic [OFS_W-1:0]         ip,
   input  logic [OFS_W-1:0]         reg_bx,
   input  logic [OFS_W-1:0]         reg_bp,
   input  logic [OFS_W-1:0]         reg_si,
   input  logic [OFS_W-1:0]         reg_di,
   input  logic [OFS_W-1:0]         seg_es,
   input  logic [OFS_W-1:0]         seg_cs,
   input  logic [OFS_W-1:0]         seg_ss,
   input  logic [OFS_W-1:0]         seg_ds,
   output logic                     out_valid,
   output logic [OFS_W-1:0]         ea,
   output logic [OFS_W+SEG_SHIFT-1:0] pa,
   output logic [1:0]               seg_code,
   output logic                     illegal
);
   import sag_pkg::*;

   localparam int PA_W = OFS_W + SEG_SHIFT;

   if (OFS_W < 2) begin : g_bad_ofs
      $error("seg_addr_gen: OFS_W too small");
   end

   logic [OFS_W-1:0] ea_raw;
   logic [OFS_W-1:0] ea_sel;
   logic [OFS_W-1:0] seg_val;
   logic [PA_W-1:0]  pa_raw;
   logic [1:0]       seg_nxt;
   logic             ill_nxt;

   sag_ea_sum #(
      .OFS_W(OFS_W), .SHORT_W(SHORT_W), .SIGN_EXT(SIGN_EXT)
   ) u_ea (
      .use_mask(use_mask), .disp_mode(disp_mode), .disp(disp),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .ea_raw(ea_raw)
   );

   sag_legal_chk u_legal (
      .req_fetch(req_fetch), .use_mask(use_mask), .disp_mode(disp_mode),
      .illegal(ill_nxt)
   );

   sag_seg_pick #(.SEG_W(OFS_W)) u_seg (
      .req_fetch(req_fetch), .str_dst(str_dst), .uses_bp(use_mask[USE_BP]),
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .seg_code(seg_nxt), .seg_val(seg_val)
   );

   always_comb begin
      if (req_fetch)    ea_sel = ip;
      else if (ill_nxt) ea_sel = '0;
      else              ea_sel = ea_raw;
   end

   sag_pa_sum #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
      .seg_val(seg_val), .offset(ea_sel), .pa_raw(pa_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ea        <= '0;
         pa        <= '0;
         seg_code  <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            ea       <= ea_sel;
            pa       <= ill_nxt ? '0 : pa_raw;
            seg_code <= seg_nxt;
            illegal  <= ill_nxt;
         end
      end
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R10
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R10
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(ea) && $stable(pa) && $stable(seg_code) && $stable(illegal))); // R10
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (ea == '0 && pa == '0)); // R7
   AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch) |=> (seg_code == SEG_CS && !illegal && ea == $past(ip))); // R6
   AST_STRING_ES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_fetch && str_dst) |=> (seg_code == SEG_ES)); // R5
   AST_PAIR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_fetch && ((use_mask[USE_BX] && use_mask[USE_BP]) ||
       (use_mask[USE_SI] && use_mask[USE_DI]))) |=> illegal); // R7
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_fetch = 1'b0, str_dst = 1'b0;
   logic [3:0]  use_mask = '0;
   logic [1:0]  disp_mode = '0;
   logic [15:0] disp = '0, ip = '0;
   logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
   logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
   logic        out_valid, illegal;
   logic [15:0] ea;
   logic [19:0] pa;
   logic [1:0]  seg_code;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
      .str_dst(str_dst), .use_mask(use_mask), .disp_mode(disp_mode), .disp(disp),
      .ip(ip), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .out_valid(out_valid), .ea(ea), .pa(pa), .seg_code(seg_code), .illegal(illegal)
   );

   // expected {valid, illegal, seg, ea, pa}
   function automatic logic [39:0] model();
      logic        ill;
      logic [1:0]  sg;
      logic [15:0] e, sv, dt;
      logic [19:0] p;
      if (req_fetch) begin
         ill = 1'b0; sg = 2'd1; e = ip; sv = seg_cs;
      end else begin
         ill = (use_mask[0] & use_mask[1]) | (use_mask[2] & use_mask[3]) |
               (disp_mode == 2'd3) | (use_mask == 4'b0010 && disp_mode == 2'd0);
         sg  = str_dst ? 2'd0 : (use_mask[1] ? 2'd2 : 2'd3);
         sv  = (sg == 2'd0) ? seg_es : (sg == 2'd2) ? seg_ss : seg_ds;
         dt  = (disp_mode == 2'd1) ? {{8{disp[7]}}, disp[7:0]} :
               (disp_mode == 2'd2) ? disp : 16'h0;
         e   = (use_mask[0] ? reg_bx : 16'h0) + (use_mask[1] ? reg_bp : 16'h0) +
               (use_mask[2] ? reg_si : 16'h0) + (use_mask[3] ? reg_di : 16'h0) + dt;
         if (ill) e = 16'h0;
      end
      p = {sv, 4'h0} + {4'h0, e};
      if (ill) p = 20'h0;
      return {1'b1, ill, sg, e, p};
   endfunction

   function automatic logic [39:0] observed();
      return {out_valid, illegal, seg_code, ea, pa};
   endfunction

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input string tag);
      logic [39:0] exp;
      exp = model();
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, observed(), exp);
   endtask

   task automatic set_regs(input logic [15:0] bx, bp, si, di, es, cs, ss, ds);
      reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
      seg_es = es; seg_cs = cs; seg_ss = ss; seg_ds = ds;
   endtask

   task automatic op(input logic f, s, input logic [3:0] m, input logic [1:0] dm,
                     input logic [15:0] d);
      req_fetch = f; str_dst = s; use_mask = m; disp_mode = dm; disp = d;
   endtask

   initial begin
      logic [39:0] snap;
      void'($urandom(32'h5EA6_0C1D));
      repeat (3) @(negedge clk);
      check("R11 reset", observed(), 40'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after release", observed(), 40'h0);

      // R1 R2 base plus long displacement: 2000+1000+1497 = 4497
      set_regs(16'h1000, 16'h0, 16'h0, 16'h0, 16'h3000, 16'h2000, 16'h1234, 16'h0200);
      op(0, 0, 4'b0001, 2'd2, 16'h1497);
      issue("R1 R2 base+disp16");
      check("R1 literal pa", {20'h0, pa}, {20'h0, 20'h04497});
      // R3 R4 BP with negative short displacement, upper byte noise
      reg_bp = 16'h0010;
      op(0, 0, 4'b0010, 2'd1, 16'hAAF0);
      issue("R3 R4 bp short neg");
      check("R3 literal ea", {24'h0, ea}, {24'h0, 16'h0000});
      // R2 effective address wrap
      reg_bx = 16'hFFFF; reg_di = 16'h0002;
      op(0, 0, 4'b1001, 2'd0, 16'h0);
      issue("R2 ea wrap");
      // R1 physical wrap
      seg_ds = 16'hFFFF; reg_si = 16'h0020;
      op(0, 0, 4'b0100, 2'd0, 16'h0);
      issue("R1 pa wrap");
      check("R1 literal wrap", {20'h0, pa}, {20'h0, 20'h00010});
      // R4 direct address uses DS
      op(0, 0, 4'b0000, 2'd2, 16'h2400);
      issue("R4 direct");
      // R5 string destination, also over BP
      reg_di = 16'h0044;
      op(0, 1, 4'b1000, 2'd0, 16'h0);
      issue("R5 string di");
      op(0, 1, 4'b0110, 2'd1, 16'h0003);
      issue("R5 string over bp");
      // R6 fetch ignores illegal operand fields
      seg_cs = 16'h24F6; ip = 16'h634A;
      op(1, 1, 4'b1111, 2'd3, 16'hFFFF);
      issue("R6 fetch");
      check("R6 literal pa", {20'h0, pa}, {20'h0, 20'h2B2AA});
      // R7 illegal pairs
      op(0, 0, 4'b0011, 2'd2, 16'h0100);
      issue("R7 bx+bp");
      op(0, 0, 4'b1100, 2'd0, 16'h0);
      issue("R7 si+di");
      // R8 BP register-indirect
      op(0, 0, 4'b0010, 2'd0, 16'h0);
      issue("R8 bp indirect");
      // R9 reserved displacement code
      op(0, 0, 4'b0001, 2'd3, 16'h0);
      issue("R9 rsvd disp");
      // R10 hold while idle
      snap = observed();
      op(0, 0, 4'b0101, 2'd2, 16'h7777);
      set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5, 16'h6, 16'h7, 16'h8);
      @(negedge clk);
      check("R10 hold", observed(), {1'b0, snap[38:0]});

      for (int i = 0; i < 400; i++) begin
         set_regs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
         ip = 16'($urandom);
         if ((i % 5) == 0) begin
            reg_bx = 16'hFFF0 | 16'($urandom_range(15));
            seg_ds = 16'hFFFF;
         end
         op(($urandom_range(7) == 0), ($urandom_range(3) == 0),
            4'($urandom), 2'($urandom), 16'($urandom));
         if (req_fetch)      issue("R6 random");
         else if (str_dst)   issue("R5 random");
         else                issue("R1 R2 R4 R7 random");
         if ((i % 16) == 7) begin
            snap = observed();
            use_mask = 4'($urandom); disp = 16'($urandom); reg_si = 16'($urandom);
            @(negedge clk);
            check("R10 random hold", observed(), {1'b0, snap[38:0]});
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule